// File: doc/BRIEF.md
# Low-Power Mode Entry and Exit Sequencer

This block walks a system from its run state into one of three retention low-power states and back again. The three states are light idle, deep idle and suspend. Each transition is a fixed list of steps aimed at the clock-mode, PLL, regulator, oscillator, reference, memory-power and peripheral-doze controls. The block issues the steps one at a time. It drives a step code together with a valid strobe, and it holds them until the addressed control answers on a ready input. The analog parts themselves sit outside the block, and only their ready answers come back in.

Software or a power policy unit requests a target state. The sequencer then runs that state's entry list. The last step of every entry list is a sleep strobe. After the sleep step the block reports the new state and waits for a wake event, and the wake event runs the exit list back to run.

Voltage and frequency are ordered by direction: frequency is lowered before voltage on the way down, and voltage is raised before frequency on the way up. A wake that arrives partway through an entry stops that entry. The block then undoes only the steps that had already completed. A step that never answers trips a timeout, which flags an error and drops the block back to run.

Top module: `pwrseq_top`

## Requirements
- R1: After reset `cur_mode` is 0, `vsel` is 0, and `busy`, `err` and `step_valid` are all low. The mode codes, used on `req_mode` and `cur_mode`, are: 0 run, 1 light idle, 2 deep idle, 3 suspend.
- R2: A step stays on `step_valid` with an unchanged `step_code` until `step_ready` is seen high on a clock edge. The next step is issued only after that. The step codes are: 1 clock WAIT, 2 clock STOP, 3 clock RUN, 4 CPU PLL reduce and unused PLLs off, 5 CPU PLL to 24 MHz source and other PLLs off, 6 PLLs restore, 7 voltage change, 8 doze (and stop) requests on, 9 doze requests off, 10 sleep, 11 DC-DC to internal oscillator, 12 DC-DC to external oscillator, 13 USB PHY off, 14 weak LDOs on and regular off, 15 regular LDOs on and weak off, 16 RC oscillator selected and crystal off, 17 crystal restarted and selected, 18 low-power bandgap in place of the main one, 19 main bandgap back, 20 RAM banks off, 21 RAM banks on, 22 CPU power-down request set, 23 CPU power-down request cleared.
- R3: Light idle entry issues 1, 4, 7, 8, 10.
- R4: Light idle exit issues 9, 7, 6, 3.
- R5: Deep idle entry issues 1, 11, 13, 5, 14, 16, 7, 18, 8, 10.
- R6: Deep idle exit issues 9, 7, 12, 17, 19, 15, 6, 3.
- R7: Suspend entry issues 2, 20, 13, 7, 11, 22, 8, 10. Step 20 is left out when `ram_off_en` was low at the time the request was accepted.
- R8: Suspend exit issues 21, 12, 23, 9, 7, 3. Step 21 is left out when step 20 was not issued on entry.
- R9: `vsel` follows completed voltage steps. It takes the encoding 0 for 1.275 V, 1 for 1.15 V, 2 for 0.95 V and 3 for 0.925 V, so an entry voltage step sets it to the target's mode code and an exit voltage step sets it to 0. A lowering voltage step is issued only after a frequency-lowering step has completed. A PLL-restore or clock-RUN step is issued only while `vsel` is 0.
- R10: The doze-on step completes before the sleep step in every entry. Every exit that follows a completed doze-on step issues doze-off.
- R11: A step left unanswered for `TMO_CYC` cycles is dropped. `err` then rises, `cur_mode` becomes 0, `vsel` becomes 0 and `busy` falls. `err` clears when the next request is accepted.
- R12: A `wake` during entry lets the in-flight step finish and then starts the exit list. The exit issues only those steps that undo entry steps which completed.
- R13: Three inputs are ignored and issue no step: a request while busy or resident, a request for mode 0, and a `wake` while in run.
- R14: `busy` is high while an entry or exit list runs. `cur_mode` shows the target after the sleep step completes, and shows 0 again once the exit completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Target-mode request strobe |
| req_mode | input | 2 | Requested mode code |
| ram_off_en | input | 1 | Power off RAM banks on suspend entry |
| wake | input | 1 | Wake event |
| step_ready | input | 1 | Addressed control has finished the step |
| step_valid | output | 1 | A step is being requested |
| step_code | output | 5 | Code of the requested step |
| vsel | output | 2 | Core voltage level selected |
| cur_mode | output | 2 | Mode the system is in |
| busy | output | 1 | Entry or exit list in progress |
| err | output | 1 | Last transition timed out |

## Verification
Every mode is taken through a full round trip, and the responder delay changes from trip to trip. This separates a correct step order from a handshake that advances without waiting. Suspend is run once with RAM power-off enabled and once with it disabled, which shows that the optional step and its mirror are dropped together. A wake is injected during deep-idle entry just as the fourth step completes, and the resulting exit list shows whether only finished work is undone. A stalled responder exercises the timeout and the clearing of the error. Stray requests and stray wakes show the inputs that are ignored.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    localparam int MODE_W = 2;
    localparam int STEP_W = 5;
    localparam int IDX_W  = 4;

    typedef logic [MODE_W-1:0] mode_t;
    typedef logic [IDX_W-1:0]  idx_t;

    localparam mode_t M_RUN   = 2'd0;
    localparam mode_t M_LIGHT = 2'd1;
    localparam mode_t M_DEEP  = 2'd2;
    localparam mode_t M_SUSP  = 2'd3;

    typedef enum logic [STEP_W-1:0] {
        S_NONE     = 5'd0,
        S_CLK_WAIT = 5'd1,
        S_CLK_STOP = 5'd2,
        S_CLK_RUN  = 5'd3,
        S_PLL_DOWN = 5'd4,
        S_PLL_24M  = 5'd5,
        S_PLL_UP   = 5'd6,
        S_VOLT     = 5'd7,
        S_DOZE_ON  = 5'd8,
        S_DOZE_OFF = 5'd9,
        S_SLEEP    = 5'd10,
        S_DCDC_INT = 5'd11,
        S_DCDC_EXT = 5'd12,
        S_USB_OFF  = 5'd13,
        S_LDO_WEAK = 5'd14,
        S_LDO_REG  = 5'd15,
        S_OSC_RC   = 5'd16,
        S_OSC_XTAL = 5'd17,
        S_BG_LP    = 5'd18,
        S_BG_MAIN  = 5'd19,
        S_RAM_OFF  = 5'd20,
        S_RAM_ON   = 5'd21,
        S_CPD_SET  = 5'd22,
        S_CPD_CLR  = 5'd23
    } step_e;

    // exit step plus the entry index whose effect it undoes
    typedef struct packed {
        step_e code;
        idx_t  dep;
    } exit_ent_t;

    function automatic idx_t entry_len(mode_t m);
        case (m)
            M_LIGHT: return idx_t'(5);
            M_DEEP:  return idx_t'(10);
            M_SUSP:  return idx_t'(8);
            default: return idx_t'(1);
        endcase
    endfunction

    function automatic idx_t exit_len(mode_t m);
        case (m)
            M_LIGHT: return idx_t'(4);
            M_DEEP:  return idx_t'(8);
            M_SUSP:  return idx_t'(6);
            default: return idx_t'(1);
        endcase
    endfunction

    function automatic step_e entry_step(mode_t m, idx_t i);
        step_e s;
        s = S_NONE;
        case (m)
            M_LIGHT: case (int'(i))
                0: s = S_CLK_WAIT;  1: s = S_PLL_DOWN; 2: s = S_VOLT;
                3: s = S_DOZE_ON;   4: s = S_SLEEP;    default: s = S_NONE;
            endcase
            M_DEEP: case (int'(i))
                0: s = S_CLK_WAIT;  1: s = S_DCDC_INT; 2: s = S_USB_OFF;
                3: s = S_PLL_24M;   4: s = S_LDO_WEAK; 5: s = S_OSC_RC;
                6: s = S_VOLT;      7: s = S_BG_LP;    8: s = S_DOZE_ON;
                9: s = S_SLEEP;     default: s = S_NONE;
            endcase
            M_SUSP: case (int'(i))
                0: s = S_CLK_STOP;  1: s = S_RAM_OFF;  2: s = S_USB_OFF;
                3: s = S_VOLT;      4: s = S_DCDC_INT; 5: s = S_CPD_SET;
                6: s = S_DOZE_ON;   7: s = S_SLEEP;    default: s = S_NONE;
            endcase
            default: s = S_NONE;
        endcase
        return s;
    endfunction

    function automatic exit_ent_t exit_step(mode_t m, idx_t i);
        exit_ent_t e;
        e = '{code: S_NONE, dep: '0};
        case (m)
            M_LIGHT: case (int'(i))
                0: e = '{S_DOZE_OFF, idx_t'(3)};
                1: e = '{S_VOLT,     idx_t'(2)};
                2: e = '{S_PLL_UP,   idx_t'(1)};
                3: e = '{S_CLK_RUN,  idx_t'(0)};
                default: e = '{S_NONE, '0};
            endcase
            M_DEEP: case (int'(i))
                0: e = '{S_DOZE_OFF, idx_t'(8)};
                1: e = '{S_VOLT,     idx_t'(6)};
                2: e = '{S_DCDC_EXT, idx_t'(1)};
                3: e = '{S_OSC_XTAL, idx_t'(5)};
                4: e = '{S_BG_MAIN,  idx_t'(7)};
                5: e = '{S_LDO_REG,  idx_t'(4)};
                6: e = '{S_PLL_UP,   idx_t'(3)};
                7: e = '{S_CLK_RUN,  idx_t'(0)};
                default: e = '{S_NONE, '0};
            endcase
            M_SUSP: case (int'(i))
                0: e = '{S_RAM_ON,   idx_t'(1)};
                1: e = '{S_DCDC_EXT, idx_t'(4)};
                2: e = '{S_CPD_CLR,  idx_t'(5)};
                3: e = '{S_DOZE_OFF, idx_t'(6)};
                4: e = '{S_VOLT,     idx_t'(3)};
                5: e = '{S_CLK_RUN,  idx_t'(0)};
                default: e = '{S_NONE, '0};
            endcase
            default: e = '{S_NONE, '0};
        endcase
        return e;
    endfunction

endpackage

// File: rtl/pwrseq_steptab.sv
module pwrseq_steptab
    import pwrseq_pkg::*;
(
    input  mode_t             mode,
    input  logic              is_exit,
    input  idx_t              idx,
    input  idx_t              done_cnt,
    input  logic              ram_lat,
    output logic [STEP_W-1:0] code,
    output logic              last,
    output logic              skip
);
    exit_ent_t xe;
    step_e     ne;

    always_comb begin
        xe = exit_step(mode, idx);
        ne = entry_step(mode, idx);
        if (is_exit) begin
            code = xe.code;
            last = (idx == exit_len(mode) - 1'b1);
            // undo only what entry finished; RAM restore only if it was cut
            skip = (xe.dep >= done_cnt) || ((xe.code == S_RAM_ON) && !ram_lat);
        end else begin
            code = ne;
            last = (idx == entry_len(mode) - 1'b1);
            skip = (ne == S_RAM_OFF) && !ram_lat;
        end
    end
endmodule

// File: rtl/pwrseq_hshk.sv
module pwrseq_hshk
    import pwrseq_pkg::*;
#(
    parameter int TMO_CYC = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [STEP_W-1:0] start_code,
    input  logic              ready,
    output logic              step_valid,
    output logic [STEP_W-1:0] step_code,
    output logic              done,
    output logic              tmo
);
    localparam int CW = $clog2(TMO_CYC + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(TMO_CYC - 1);

    logic [CW-1:0] cnt;

    assign done = step_valid & ready;
    assign tmo  = step_valid & ~ready & (cnt == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            step_valid <= 1'b0;
            step_code  <= '0;
            cnt        <= '0;
        end else if (done || tmo) begin
            step_valid <= 1'b0;
            cnt        <= '0;
        end else if (step_valid) begin
            cnt <= cnt + 1'b1;
        end else if (start) begin
            step_valid <= 1'b1;
            step_code  <= start_code;
            cnt        <= '0;
        end
    end

    AST_HOLD_STEP: assert property (@(posedge clk) disable iff (rst)
        (step_valid && !ready && !tmo) |=> (step_valid && $stable(step_code))); // R2
endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
    import pwrseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  mode_t             req_mode,
    input  logic              ram_off_en,
    input  logic              wake,
    input  logic              hs_active,
    input  logic              hs_done,
    input  logic              hs_tmo,
    input  logic [STEP_W-1:0] hs_code,
    input  logic              tab_last,
    input  logic              tab_skip,
    output mode_t             tab_mode,
    output logic              tab_exit,
    output idx_t              tab_idx,
    output idx_t              tab_done,
    output logic              tab_ram,
    output logic              hs_start,
    output mode_t             cur_mode,
    output mode_t             vsel,
    output logic              busy,
    output logic              err
);
    typedef enum logic [1:0] {ST_IDLE, ST_ENTRY, ST_RESIDENT, ST_EXIT} st_e;

    st_e   st;
    mode_t tgt;
    idx_t  idx, done_cnt;
    logic  ram_lat, wake_lat, doze_on, freq_low;
    logic  in_seq, step_fin;

    assign in_seq   = (st == ST_ENTRY) || (st == ST_EXIT);
    assign hs_start = in_seq && !hs_active && !tab_skip;
    assign step_fin = hs_done || (in_seq && !hs_active && tab_skip);
    assign busy     = in_seq;

    assign tab_mode = tgt;
    assign tab_exit = (st == ST_EXIT);
    assign tab_idx  = idx;
    assign tab_done = done_cnt;
    assign tab_ram  = ram_lat;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            tgt      <= M_RUN;
            idx      <= '0;
            done_cnt <= '0;
            ram_lat  <= 1'b0;
            wake_lat <= 1'b0;
            doze_on  <= 1'b0;
            freq_low <= 1'b0;
            cur_mode <= M_RUN;
            vsel     <= M_RUN;
            err      <= 1'b0;
        end else if (hs_tmo) begin
            st       <= ST_IDLE;
            err      <= 1'b1;
            cur_mode <= M_RUN;
            vsel     <= M_RUN;
            doze_on  <= 1'b0;
            freq_low <= 1'b0;
            wake_lat <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (req_valid && req_mode != M_RUN) begin
                    tgt      <= req_mode;
                    ram_lat  <= ram_off_en;
                    idx      <= '0;
                    done_cnt <= '0;
                    wake_lat <= 1'b0;
                    err      <= 1'b0;
                    st       <= ST_ENTRY;
                end
                ST_ENTRY: begin
                    if (wake) wake_lat <= 1'b1;
                    if (step_fin) begin
                        done_cnt <= idx + 1'b1;
                        if (wake || wake_lat) begin
                            st  <= ST_EXIT;
                            idx <= '0;
                        end else if (tab_last) begin
                            st       <= ST_RESIDENT;
                            cur_mode <= tgt;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                ST_RESIDENT: if (wake) begin
                    st  <= ST_EXIT;
                    idx <= '0;
                end
                default: if (step_fin) begin
                    if (tab_last) begin
                        st       <= ST_IDLE;
                        cur_mode <= M_RUN;
                        wake_lat <= 1'b0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
            endcase

            if (hs_done) begin
                if (hs_code == S_VOLT)
                    vsel <= (st == ST_ENTRY) ? tgt : M_RUN;
                if (hs_code == S_DOZE_ON)  doze_on <= 1'b1;
                if (hs_code == S_DOZE_OFF) doze_on <= 1'b0;
                if (hs_code == S_PLL_DOWN || hs_code == S_PLL_24M || hs_code == S_CLK_STOP)
                    freq_low <= 1'b1;
                if (hs_code == S_PLL_UP || hs_code == S_CLK_RUN)
                    freq_low <= 1'b0;
            end
        end
    end

    AST_DOZE_BEFORE_SLEEP: assert property (@(posedge clk) disable iff (rst)
        (hs_active && hs_code == S_SLEEP) |-> doze_on); // R10
    AST_DOZE_CLEARED: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && cur_mode == M_RUN && !err) |-> !doze_on); // R10
    AST_FREQ_BEFORE_VDROP: assert property (@(posedge clk) disable iff (rst)
        (hs_active && hs_code == S_VOLT && st == ST_ENTRY && vsel == M_RUN) |-> freq_low); // R9
    AST_VRAISE_BEFORE_FREQ: assert property (@(posedge clk) disable iff (rst)
        (hs_active && (hs_code == S_PLL_UP || hs_code == S_CLK_RUN)) |-> vsel == M_RUN); // R9
    AST_TMO_TO_RUN: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> (cur_mode == M_RUN && !busy && vsel == M_RUN)); // R11
    AST_QUIET_WHEN_SETTLED: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE || st == ST_RESIDENT) |-> !hs_active); // R13
endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
    import pwrseq_pkg::*;
#(
    parameter int TMO_CYC = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic [1:0] req_mode,
    input  logic       ram_off_en,
    input  logic       wake,
    input  logic       step_ready,
    output logic       step_valid,
    output logic [4:0] step_code,
    output logic [1:0] vsel,
    output logic [1:0] cur_mode,
    output logic       busy,
    output logic       err
);
    mode_t             tab_mode;
    logic              tab_exit, tab_ram, tab_last, tab_skip;
    idx_t              tab_idx, tab_done;
    logic [STEP_W-1:0] tab_code;
    logic              hs_start, hs_done, hs_tmo;

    pwrseq_steptab u_tab (
        .mode     (tab_mode),
        .is_exit  (tab_exit),
        .idx      (tab_idx),
        .done_cnt (tab_done),
        .ram_lat  (tab_ram),
        .code     (tab_code),
        .last     (tab_last),
        .skip     (tab_skip)
    );

    pwrseq_hshk #(.TMO_CYC(TMO_CYC)) u_hs (
        .clk        (clk),
        .rst        (rst),
        .start      (hs_start),
        .start_code (tab_code),
        .ready      (step_ready),
        .step_valid (step_valid),
        .step_code  (step_code),
        .done       (hs_done),
        .tmo        (hs_tmo)
    );

    pwrseq_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_mode   (req_mode),
        .ram_off_en (ram_off_en),
        .wake       (wake),
        .hs_active  (step_valid),
        .hs_done    (hs_done),
        .hs_tmo     (hs_tmo),
        .hs_code    (step_code),
        .tab_last   (tab_last),
        .tab_skip   (tab_skip),
        .tab_mode   (tab_mode),
        .tab_exit   (tab_exit),
        .tab_idx    (tab_idx),
        .tab_done   (tab_done),
        .tab_ram    (tab_ram),
        .hs_start   (hs_start),
        .cur_mode   (cur_mode),
        .vsel       (vsel),
        .busy       (busy),
        .err        (err)
    );
endmodule

// File: tb/sim_pwrseq_top.sv
`timescale 1ns/1ps
module sim_pwrseq_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [1:0] req_mode = 2'd0;
    logic       ram_off_en = 1'b0;
    logic       wake = 1'b0;
    logic       step_ready = 1'b0;
    logic       step_valid;
    logic [4:0] step_code;
    logic [1:0] vsel, cur_mode;
    logic       busy, err;

    always #2 clk = ~clk;

    pwrseq_top #(.TMO_CYC(64)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
        .ram_off_en(ram_off_en), .wake(wake), .step_ready(step_ready),
        .step_valid(step_valid), .step_code(step_code), .vsel(vsel),
        .cur_mode(cur_mode), .busy(busy), .err(err)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [4:0] log_q [0:127];
    int log_n = 0;
    int dly = 0;
    bit stall = 1'b0;
    int hold_bad = 0;

    // mode, ram flag, list lengths, packed expected step codes (step 0 in low bits)
    localparam logic [1:0]  V_MODE [4] = '{2'd1, 2'd2, 2'd3, 2'd3};
    localparam logic        V_RAM  [4] = '{1'b0, 1'b0, 1'b1, 1'b0};
    localparam int          V_NEN  [4] = '{5, 10, 8, 7};
    localparam int          V_NEX  [4] = '{4, 8, 6, 5};
    localparam logic [49:0] V_EN   [4] = '{
        {25'd0, 5'd10, 5'd8, 5'd7, 5'd4, 5'd1},
        {5'd10, 5'd8, 5'd18, 5'd7, 5'd16, 5'd14, 5'd5, 5'd13, 5'd11, 5'd1},
        {10'd0, 5'd10, 5'd8, 5'd22, 5'd11, 5'd7, 5'd13, 5'd20, 5'd2},
        {15'd0, 5'd10, 5'd8, 5'd22, 5'd11, 5'd7, 5'd13, 5'd2}};
    localparam logic [49:0] V_EX   [4] = '{
        {30'd0, 5'd3, 5'd6, 5'd7, 5'd9},
        {10'd0, 5'd3, 5'd6, 5'd15, 5'd19, 5'd17, 5'd12, 5'd7, 5'd9},
        {20'd0, 5'd3, 5'd7, 5'd9, 5'd23, 5'd12, 5'd21},
        {25'd0, 5'd3, 5'd7, 5'd9, 5'd23, 5'd12}};

    function automatic string tag_en(int v);
        case (v) 0: return "R3"; 1: return "R5"; default: return "R7";
        endcase
    endfunction
    function automatic string tag_ex(int v);
        case (v) 0: return "R4"; 1: return "R6"; default: return "R8";
        endcase
    endfunction

    // step responder: answers each step after dly cycles, logs the code
    initial begin
        int wcnt = 0;
        bit pv = 1'b0, pr = 1'b0;
        logic [4:0] pc = '0;
        forever begin
            @(negedge clk);
            if (pv && !pr && !stall && (!step_valid || step_code != pc)) hold_bad++;
            if (step_ready) step_ready = 1'b0;
            else if (step_valid && !stall) begin
                if (wcnt >= dly) begin
                    step_ready = 1'b1;
                    log_q[log_n] = step_code;
                    log_n++;
                    wcnt = 0;
                end else wcnt++;
            end
            pv = step_valid; pr = step_ready; pc = step_code;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_seq(input string req, input int base, input int n, input logic [49:0] exp);
        int at = -1, act = 0, ex = 0;
        if (log_n - base != n) begin
            at = 99; act = log_n - base; ex = n;
        end else begin
            for (int i = 0; i < n; i++)
                if (at < 0 && log_q[base+i] != exp[i*5 +: 5]) begin
                    at = i; act = log_q[base+i]; ex = exp[i*5 +: 5];
                end
        end
        n_chk++;
        if (at >= 0) begin
            n_bad++;
            $display("FAIL %s step list at %0d: actual=%0d expected=%0d", req, at, act, ex);
        end
    endtask

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic request(input logic [1:0] m, input logic ram);
        tick();
        req_valid = 1'b1; req_mode = m; ram_off_en = ram;
        tick();
        req_valid = 1'b0; req_mode = 2'd0; ram_off_en = 1'b0;
    endtask

    task automatic pulse_wake();
        tick(); wake = 1'b1;
        tick(); wake = 1'b0;
    endtask

    task automatic wait_quiet();
        for (int c = 0; c < 2000 && busy; c++) tick();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog expired actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int base;
        bit found;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        check(cur_mode == 2'd0 && vsel == 2'd0, "R1 mode/vsel", {cur_mode, vsel}, 0);
        check(!busy && !err && !step_valid, "R1 flags", {busy, err, step_valid}, 0);

        // round trips through every mode, varied responder delay
        for (int v = 0; v < 4; v++) begin
            dly = v;
            base = log_n;
            request(V_MODE[v], V_RAM[v]);
            check(busy, "R14 busy during entry", busy, 1);
            wait_quiet();
            check_seq(tag_en(v), base, V_NEN[v], V_EN[v]);
            check(cur_mode == V_MODE[v], "R14 resident mode", cur_mode, V_MODE[v]);
            check(vsel == V_MODE[v], "R9 lowered voltage", vsel, V_MODE[v]);
            check(log_q[log_n-1] == 5'd10 && log_q[log_n-2] == 5'd8,
                  "R10 doze before sleep", log_q[log_n-2], 8);
            base = log_n;
            pulse_wake();
            wait_quiet();
            check_seq(tag_ex(v), base, V_NEX[v], V_EX[v]);
            check(cur_mode == 2'd0 && !busy, "R14 back in run", cur_mode, 0);
            check(vsel == 2'd0, "R9 raised voltage", vsel, 0);
            found = 1'b0;
            for (int i = base; i < log_n; i++) if (log_q[i] == 5'd9) found = 1'b1;
            check(found, "R10 doze cleared on exit", found, 1);
        end
        check(hold_bad == 0, "R2 step held until ready", hold_bad, 0);

        // R13: stray requests and wakes
        dly = 0;
        base = log_n;
        request(2'd0, 1'b0);
        repeat (5) tick();
        check(!busy && log_n == base, "R13 run request ignored", log_n - base, 0);
        pulse_wake();
        repeat (5) tick();
        check(!busy && log_n == base && cur_mode == 2'd0, "R13 wake in run ignored", log_n - base, 0);
        request(2'd1, 1'b0);
        wait_quiet();
        base = log_n;
        request(2'd2, 1'b0);
        repeat (20) tick();
        check(log_n == base && cur_mode == 2'd1, "R13 request while resident ignored", log_n - base, 0);
        pulse_wake();
        wait_quiet();

        // R12: wake during deep entry as the fourth step finishes
        dly = 2;
        base = log_n;
        request(2'd2, 1'b0);
        for (int c = 0; c < 500 && (log_n - base) < 4; c++) tick();
        wake = 1'b1;
        tick();
        wake = 1'b0;
        wait_quiet();
        check_seq("R12 abort list", base, 7,
                  {15'd0, 5'd3, 5'd6, 5'd12, 5'd5, 5'd13, 5'd11, 5'd1});
        check(cur_mode == 2'd0 && vsel == 2'd0, "R12 never resident", {cur_mode, vsel}, 0);

        // R11: stalled step times out
        dly = 0;
        stall = 1'b1;
        base = log_n;
        request(2'd1, 1'b0);
        wait_quiet();
        check(err, "R11 error raised", err, 1);
        check(cur_mode == 2'd0 && !busy && !step_valid, "R11 back to run", {cur_mode, busy, step_valid}, 0);
        stall = 1'b0;
        request(2'd1, 1'b0);
        check(!err, "R11 error cleared by request", err, 0);
        wait_quiet();
        check(cur_mode == 2'd1, "R11 recovers", cur_mode, 1);
        pulse_wake();
        wait_quiet();
        check(cur_mode == 2'd0, "R14 final run", cur_mode, 0);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule